// File: doc/BRIEF.md
# Clock Control Register File

This block is the 32-bit software-visible register bank of a clock and reset controller. A host reaches it through a plain word-wide bus: a word offset, a read strobe and a write strobe. The bank holds clock gate enables, clock source selects, divider words, peripheral reset words, watchdog reset-control words and core reset-control words. Each of these comes out of cold reset at a fixed value. Four of the words control PLLs. Their lock-indicate and loss-of-lock bits are computed when the word is written, which stands in for a real lock detector.

Two locations show free-running time counters that live outside the block. Reads of these locations return the counter inputs. One location is a write-only software-reset trigger. Accesses that go past the last word, or that use the wrong direction for a location, return zero and raise a one-cycle error pulse. Read data is registered and comes back one cycle after the read strobe.

Top module: `clk_ctrl_regfile`

## Requirements
- R1: While `rst_n` is low, every word loads its cold value. Words 0, 10 and 12 (clock enables) and words 14, 15 and 16 (watchdog reset control) load 0xFFFFFFFF. Word 1 loads 0x004AAAAA, word 2 loads 0x5413F855, word 11 loads 0xAA4F8F9F, word 8 loads 0x00001000, word 9 loads 0x80000000, word 13 loads 0x03000000, word 17 loads 0x00000003, word 23 loads 0x04000003 and word 25 loads 0x000000C8. The PLL words load 0x80222101 (word 3), 0x80202101 (word 4), 0x80C02105 (word 21) and 0x81228606 (word 24). All other stored words load 0.
- R2: A write to an ordinary stored word (words 0–2, 6–25 except the PLL words) stores all 32 bits as written. A read strobe returns the word on `rdata` one cycle later, with `rd_valid` high for exactly that cycle.
- R3: A write to a PLL word (3, 4, 21, 24) with bit 12 (power-down) set stores the written data with bit 31 (lock-indicate) cleared and bit 30 (loss-of-lock) set.
- R4: A write to a PLL word with bit 12 clear stores the written data with bit 31 forced to 1. Bit 30 becomes 0 if it was written as 1, and keeps its previous stored value if it was written as 0.
- R5: Word 5 (software-reset trigger) is write-only. A write to it is accepted with no error and has no lasting effect. A read of it returns 0 and raises `err`.
- R6: Word 27 (tick counter) is read-only. A read returns `tick_count`. A write is ignored and raises `err`.
- R7: Reads of word 26 (seconds counter) return `sec_count`. A write to word 26 has no effect and raises no error.
- R8: For any offset of 28 or more, a read returns 0 and a write changes nothing. Either access raises `err`.
- R9: `err` is high only in the cycle after an illegal access. `rdata` holds its value in every cycle that follows a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset, asynchronous |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word offset (byte offset / 4) |
| wdata | input | 32 | Write data |
| sec_count | input | 32 | External seconds counter, read at word 26 |
| tick_count | input | 32 | External tick counter, read at word 27 |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read strobe |
| err | output | 1 | Pulses the cycle after an illegal access |

## Verification
The hardest case to reach from the ports is the loss-of-lock flag surviving a normal-mode PLL write. To get there, a power-down write must first set the flag, and a later write must then have bit 12 clear and bit 30 clear. Uniform random data hits that pairing only now and then. The stimulus therefore steers half of its random offsets onto the four PLL words and picks bits 12 and 30 with their own coin tosses. Directed sequences then walk each PLL word through set, hold and clear of the flag.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
   localparam int DATA_W    = 32;
   localparam int NUM_WORDS = 28;
   localparam int LOCK_BIT  = 31;
   localparam int LOSS_BIT  = 30;
   localparam int PDN_BIT   = 12;
   localparam int W_SWRST   = 5;
   localparam int W_SEC     = 26;
   localparam int W_TICK    = 27;

   typedef enum logic [2:0] {
      KIND_PLAIN,
      KIND_PLL,
      KIND_WONLY,
      KIND_SEC,
      KIND_TICK
   } word_kind_e;

   function automatic word_kind_e kind_of(input int idx);
      case (idx)
         3, 4, 21, 24: return KIND_PLL;
         W_SWRST:      return KIND_WONLY;
         W_SEC:        return KIND_SEC;
         W_TICK:       return KIND_TICK;
         default:      return KIND_PLAIN;
      endcase
   endfunction

   function automatic logic [DATA_W-1:0] cold_value(input int idx);
      case (idx)
         0, 10, 12, 14, 15, 16: return 32'hFFFF_FFFF;
         1:  return 32'h004A_AAAA;
         2:  return 32'h5413_F855;
         3:  return 32'h8022_2101;
         4:  return 32'h8020_2101;
         8:  return 32'h0000_1000;
         9:  return 32'h8000_0000;
         11: return 32'hAA4F_8F9F;
         13: return 32'h0300_0000;
         17: return 32'h0000_0003;
         21: return 32'h80C0_2105;
         23: return 32'h0400_0003;
         24: return 32'h8122_8606;
         25: return 32'h0000_00C8;
         default: return '0;
      endcase
   endfunction
endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode
   import clkreg_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_WORDS-1:0] hit,
   output logic                 in_range
);
   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_hit
      assign hit[i] = (addr == ADDR_W'(i));
   end
   assign in_range = |hit;
endmodule

// File: rtl/clkreg_pll_next.sv
module clkreg_pll_next
   import clkreg_pkg::*;
(
   input  logic [DATA_W-1:0] old_q,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] nxt
);
   always_comb begin
      nxt = wdata;
      if (wdata[PDN_BIT]) begin
         nxt[LOCK_BIT] = 1'b0;
         nxt[LOSS_BIT] = 1'b1;
      end else begin
         nxt[LOCK_BIT] = 1'b1;
         nxt[LOSS_BIT] = wdata[LOSS_BIT] ? 1'b0 : old_q[LOSS_BIT];
      end
   end
endmodule

// File: rtl/clkreg_word.sv
module clkreg_word
   import clkreg_pkg::*;
#(
   parameter logic [DATA_W-1:0] RST_VAL = '0,
   parameter bit                IS_PLL  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] nxt;

   if (IS_PLL) begin : g_pll
      clkreg_pll_next u_next (
         .old_q (q),
         .wdata (wdata),
         .nxt   (nxt)
      );

      // R3
      pdn_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && wdata[PDN_BIT]) |=> (!q[LOCK_BIT] && q[LOSS_BIT]));
      // R4
      run_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && !wdata[PDN_BIT]) |=> q[LOCK_BIT]);
      // R4
      loss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && !wdata[PDN_BIT] && !wdata[LOSS_BIT]) |=> (q[LOSS_BIT] == $past(q[LOSS_BIT])));
      // R4
      loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && !wdata[PDN_BIT] && wdata[LOSS_BIT]) |=> !q[LOSS_BIT]);
   end else begin : g_plain
      assign nxt = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= nxt;
   end
endmodule

// File: rtl/clk_ctrl_regfile.sv
module clk_ctrl_regfile
   import clkreg_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [31:0]       sec_count,
   input  logic [31:0]       tick_count,
   output logic [31:0]       rdata,
   output logic              rd_valid,
   output logic              err
);
   localparam int MIN_ADDR_W = $clog2(NUM_WORDS);

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("clk_ctrl_regfile: ADDR_W too small for the word count");
   end
   if (DATA_W != 32) begin : g_bad_data_w
      $error("clk_ctrl_regfile: lock bit positions need a 32-bit word");
   end

   logic [NUM_WORDS-1:0] hit;
   logic                 in_range;
   logic [DATA_W-1:0]    word_q [NUM_WORDS];
   logic [DATA_W-1:0]    rd_mux;
   logic                 err_nxt;

   clkreg_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr     (addr),
      .hit      (hit),
      .in_range (in_range)
   );

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam word_kind_e KIND = kind_of(i);
      if (KIND == KIND_PLAIN || KIND == KIND_PLL) begin : g_store
         clkreg_word #(
            .RST_VAL (cold_value(i)),
            .IS_PLL  (KIND == KIND_PLL)
         ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && hit[i]),
            .wdata (wdata),
            .q     (word_q[i])
         );
      end else if (KIND == KIND_SEC) begin : g_sec
         assign word_q[i] = sec_count;
      end else if (KIND == KIND_TICK) begin : g_tick
         assign word_q[i] = tick_count;
      end else begin : g_wonly
         assign word_q[i] = '0;
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (hit[i]) rd_mux = word_q[i];
      end
   end

   assign err_nxt = (rd_en && (!in_range || hit[W_SWRST])) ||
                    (wr_en && (!in_range || hit[W_TICK]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
         err      <= 1'b0;
      end else begin
         if (rd_en) rdata <= rd_mux;
         rd_valid <= rd_en;
         err      <= err_nxt;
      end
   end

   // R2
   rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   // R8
   oor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_en || wr_en) && addr >= ADDR_W'(NUM_WORDS)) |=> err);
   // R8
   oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr >= ADDR_W'(NUM_WORDS)) |=> (rdata == '0));
   // R5
   swrst_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(W_SWRST)) |=> (rdata == '0 && err));
   // R9
   quiet_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !wr_en) |=> !err);
   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_clk_ctrl_regfile.sv
module tb_clk_ctrl_regfile;
   localparam int AW = 10;
   localparam int NW = 28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   sec_count = 32'd0;
   logic [31:0]   tick_count = 32'd0;
   logic [31:0]   rdata;
   logic          rd_valid;
   logic          err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] model [NW];

   always #4 clk = ~clk;

   clk_ctrl_regfile #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .sec_count(sec_count), .tick_count(tick_count),
      .rdata(rdata), .rd_valid(rd_valid), .err(err)
   );

   function automatic logic [31:0] cold(input int i);
      case (i)
         0, 10, 12, 14, 15, 16: return 32'hFFFFFFFF;
         1: return 32'h004AAAAA;   2: return 32'h5413F855;
         3: return 32'h80222101;   4: return 32'h80202101;
         8: return 32'h00001000;   9: return 32'h80000000;
         11: return 32'hAA4F8F9F;  13: return 32'h03000000;
         17: return 32'h00000003;  21: return 32'h80C02105;
         23: return 32'h04000003;  24: return 32'h81228606;
         25: return 32'h000000C8;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit is_pll(input int a);
      return a == 3 || a == 4 || a == 21 || a == 24;
   endfunction

   function automatic logic [31:0] pll_rule(input logic [31:0] old, input logic [31:0] d);
      logic [31:0] r;
      r = d;
      if (d[12]) begin r[31] = 1'b0; r[30] = 1'b1; end
      else begin r[31] = 1'b1; r[30] = d[30] ? 1'b0 : old[30]; end
      return r;
   endfunction

   function automatic logic [31:0] exp_read(input int a);
      if (a >= NW || a == 5) return 32'h0;
      if (a == 26) return sec_count;
      if (a == 27) return tick_count;
      return model[a];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input int a, input logic [31:0] d, input string tag);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      check({tag, " write err"}, {31'd0, err}, {31'd0, (a >= NW || a == 27)});
      if (a < NW && a != 5 && a != 26 && a != 27)
         model[a] = is_pll(a) ? pll_rule(model[a], d) : d;
   endtask

   task automatic do_read(input int a, input string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      check({tag, " rdata"}, rdata, exp_read(a));
      check({tag, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
      check({tag, " read err"}, {31'd0, err}, {31'd0, (a >= NW || a == 5)});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      for (int i = 0; i < NW; i++) model[i] = cold(i);
      sec_count = 32'd17; tick_count = 32'h0012_3450;
      repeat (3) @(negedge clk);
      check("R1 rdata in reset", rdata, 32'h0);
      check("R9 err in reset", {31'd0, err}, 32'd0);
      rst_n = 1'b1;
      // R1: every word read straight after reset
      for (int i = 0; i < NW; i++) do_read(i, "R1");

      // R2: ordinary words
      do_write(2, 32'hDEADBEEF, "R2");  do_read(2, "R2");
      do_write(22, 32'h0000_0001, "R2"); do_read(22, "R2");

      // R3 then R4 on PLL0: set, hold, clear loss flag
      do_write(3, 32'h0000_1000, "R3"); do_read(3, "R3");
      do_write(3, 32'h0000_0555, "R4 hold"); do_read(3, "R4 hold");
      check("R4 hold flag", {31'd0, rdata[30]}, 32'd1);
      do_write(3, 32'h4000_0555, "R4 clear"); do_read(3, "R4 clear");
      check("R4 clear flag", {31'd0, rdata[30]}, 32'd0);
      do_write(24, 32'hC000_1FFF, "R3"); do_read(24, "R3");

      // R5 software-reset word
      do_write(5, 32'hFFFFFFFF, "R5"); do_read(5, "R5");
      // R6 tick counter
      do_write(27, 32'hAAAA5555, "R6"); do_read(27, "R6");
      // R7 seconds counter
      do_write(26, 32'h12345678, "R7"); do_read(26, "R7");
      // R8 out of range
      do_write(28, 32'h11111111, "R8"); do_read(28, "R8");
      do_write(1023, 32'h22222222, "R8"); do_read(1023, "R8");
      do_read(1, "R8 no alias");

      // R9: idle cycle leaves rdata and err quiet
      do_read(25, "R9");
      held = rdata;
      @(negedge clk);
      check("R9 rdata hold", rdata, held);
      check("R9 idle err", {31'd0, err}, 32'd0);
      check("R9 idle rd_valid", {31'd0, rd_valid}, 32'd0);

      // random traffic, half steered at PLL words
      void'($urandom(32'd20240611));
      for (int n = 0; n < 400; n++) begin
         int a;
         logic [31:0] d;
         sec_count = $urandom; tick_count = $urandom;
         if ($urandom_range(0, 1) == 0) begin
            case ($urandom_range(0, 3))
               0: a = 3; 1: a = 4; 2: a = 21; default: a = 24;
            endcase
         end else a = $urandom_range(0, 31);
         d = $urandom;
         d[12] = ($urandom_range(0, 2) == 0);
         d[30] = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 1) == 0) do_write(a, d, "R2/R4 random");
         do_read(a, "R2/R4 random");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule